// File: doc/BRIEF.md
# I2C Master Transmit Controller

This block drives a two-wire serial bus as a master that only sends data. A CPU programs it through three byte-wide registers: a control register, a status register and a data register. Software first confirms the bus is free by reading a line-derived busy bit. It selects master-transmit operation and requests a START. It then writes bytes one at a time: the address byte first, then payload. Each byte is shifted out MSB first, followed by a ninth clock in which the slave's acknowledge is sampled into the status register. Software finishes the transfer by requesting a STOP.

A single sticky event flag paces the transfer. The flag is raised when the START has been placed on the bus and again when each byte's acknowledge clock has ended. Software clears it after each data write. Both bus lines are open-drain: the block only ever pulls a line low or lets it go. A bus monitor watches the real line levels through synchronisers. It marks the bus busy on any START it sees and free on any STOP, whether or not this block issued it.

Register map (2-bit address): 0 = control, 1 = status, 2 = data, 3 reads as zero. Control bits: [7] bus busy (read: monitor state; write: command bit), [5] master select, [4] transmit select, [1] command qualifier, [0] event flag. All other control bits read 0. Status bit [0] holds the captured acknowledge.

Top module: `i2c_mtx_ctrl`

## Requirements
- R1: After reset the control, status and data registers read 0x00, the event output is 0, and neither bus line is pulled low.
- R2: Control bit 7 reads 1 after a START (SDA falls while SCL is high) is seen on the lines, including one made by another master. It reads 0 after a STOP (SDA rises while SCL is high) is seen.
- R3: A control write with bit 7 = 1, bit 1 = 0, bit 5 = 1 and bit 4 = 1, made while control bit 7 reads 0 and the engine is idle, puts a START on the bus. SDA falls while SCL is high, then SCL is pulled low. The event flag (control bit 0 and the irq port) is then set.
- R4: A START request has no effect on the lines or on the event flag in three cases: control bit 7 reads 1, the write carries bit 1 = 1, or the write does not set both bit 5 and bit 4.
- R5: A data-register write made while the bus is owned and between bytes sends the byte MSB first, then a ninth clock with SDA released. SDA changes only while SCL is low.
- R6: The SDA level sampled during the ninth clock is stored in status bit 0 (0 = acknowledge, 1 = no acknowledge), and the event flag is set when that clock ends.
- R7: The event flag is sticky. Writing control bit 0 = 0 clears it, writing 1 does not set it, and the irq port always equals it.
- R8: A control write with bit 7 = 0 and bit 1 = 0, made while the bus is owned and between bytes, puts a STOP on the bus. Both lines are then released, control bit 7 returns to 0, and the event flag is not set.
- R9: A data-register write made while the bus is not owned, or while a byte is being shifted, produces no SCL activity and does not change the byte on the bus.
- R10: Within a byte, SCL stays high for 2*CLK_DIV clock cycles in each bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| irq | output | 1 | Event flag |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The embedded properties assume that no slave holds SCL low and that no other master touches the lines while this block owns the bus. Under those assumptions, the level this block drives is the level it later senses. They also assume that software issues a STOP only between bytes. The bench's slave model never stretches the clock. It pulls SDA only in the acknowledge slot of a frame this block started. The bench plays another master only while this block is idle, and it sequences all register writes the way software would.

// File: rtl/i2c_mtx_pkg.sv
// Package: register addresses, control bit positions and sequencer states
// shared by the master-transmit controller modules.
package i2c_mtx_pkg;
    localparam int            REG_AW = 2;
    localparam logic [1:0]    A_CTRL = 2'd0;
    localparam logic [1:0]    A_STAT = 2'd1;
    localparam logic [1:0]    A_DATA = 2'd2;
    localparam int            C_FLAG = 0;
    localparam int            C_QUAL = 1;
    localparam int            C_DIR  = 4;
    localparam int            C_MST  = 5;
    localparam int            C_BUSY = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_HOLD,
        ST_BIT,
        ST_STOP
    } seq_state_t;
endpackage

// File: rtl/i2c_mtx_busmon.sv
// Bus monitor: synchronises the sensed SCL/SDA levels and keeps a busy
// flag that follows START and STOP conditions from any master.
// Assumes SYNC_STAGES >= 2 and that the lines idle high.
module i2c_mtx_busmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic bus_busy
);
    logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
    logic scl_s, scl_prev, sda_prev;
    logic start_det, stop_det;

    assign scl_s = scl_sr[SYNC_STAGES-1];
    assign sda_s = sda_sr[SYNC_STAGES-1];

    // Synchroniser chains and one-cycle history of the synced levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sr   <= '1;
            sda_sr   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sr   <= {scl_sr[SYNC_STAGES-2:0], scl_in};
            sda_sr   <= {sda_sr[SYNC_STAGES-2:0], sda_in};
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign start_det = scl_prev & scl_s &  sda_prev & ~sda_s;
    assign stop_det  = scl_prev & scl_s & ~sda_prev &  sda_s;

    // Busy flag: set on a seen START, cleared on a seen STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)         bus_busy <= 1'b0;
        else if (start_det) bus_busy <= 1'b1;
        else if (stop_det)  bus_busy <= 1'b0;
    end

    p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && scl_prev && sda_prev && !sda_s) |=> bus_busy);
    p_free_on_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && scl_prev && !sda_prev && sda_s) |=> !bus_busy);
endmodule

// File: rtl/i2c_mtx_seq.sv
// Bus sequencer: generates START, the data bits plus acknowledge clock,
// and STOP, at a quarter-bit period of CLK_DIV clocks. It drives both
// lines open-drain from registers. Assumes no clock stretching and
// no other master active while it owns the bus.
module i2c_mtx_seq
    import i2c_mtx_pkg::*;
#(
    parameter int CLK_DIV = 125,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              data_go,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sda_s,
    input  logic              bus_busy,
    output logic              seq_idle,
    output logic              seq_hold,
    output logic              evt,
    output logic              ack_vld,
    output logic              ack_val,
    output logic              scl_low,
    output logic              sda_low
);
    localparam int CW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam int BW = $clog2(DATA_W + 1);

    seq_state_t        state;
    logic [CW-1:0]     cnt;
    logic [1:0]        qtr;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] shreg;
    logic              active, tick, last_bit;

    assign active   = (state == ST_START) || (state == ST_BIT) || (state == ST_STOP);
    assign tick     = active && (cnt == CW'(CLK_DIV - 1));
    assign last_bit = (bidx == BW'(DATA_W));
    assign seq_idle = (state == ST_IDLE);
    assign seq_hold = (state == ST_HOLD);
    assign ack_vld  = tick && (qtr == 2'd3) && (state == ST_BIT) && last_bit;
    assign ack_val  = sda_s;
    assign evt      = tick && (qtr == 2'd3) &&
                      ((state == ST_START) || ((state == ST_BIT) && last_bit));

    // Quarter-period timer, running only in the timed states.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (!active || tick)   cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end

    // Main sequencer: state, quarter index, shifter and line drivers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            qtr     <= 2'd0;
            bidx    <= '0;
            shreg   <= '0;
            scl_low <= 1'b0;
            sda_low <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start_req) begin
                    state <= ST_START;
                    qtr   <= 2'd0;
                end
                ST_START: if (tick) begin
                    qtr <= qtr + 2'd1;
                    case (qtr)
                        2'd0:    sda_low <= 1'b1;
                        2'd2:    scl_low <= 1'b1;
                        2'd3:    state   <= ST_HOLD;
                        default: ;
                    endcase
                end
                ST_HOLD: if (data_go) begin
                    state <= ST_BIT;
                    shreg <= wdata;
                    bidx  <= '0;
                    qtr   <= 2'd0;
                end else if (stop_req) begin
                    state <= ST_STOP;
                    qtr   <= 2'd0;
                end
                ST_BIT: if (tick) begin
                    qtr <= qtr + 2'd1;
                    case (qtr)
                        2'd0:    sda_low <= last_bit ? 1'b0 : ~shreg[DATA_W-1];
                        2'd1:    scl_low <= 1'b0;
                        2'd3: begin
                            scl_low <= 1'b1;
                            if (last_bit) begin
                                state <= ST_HOLD;
                            end else begin
                                shreg <= {shreg[DATA_W-2:0], 1'b0};
                                bidx  <= bidx + 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                ST_STOP: if (tick) begin
                    qtr <= qtr + 2'd1;
                    case (qtr)
                        2'd0:    sda_low <= 1'b1;
                        2'd1:    scl_low <= 1'b0;
                        2'd2:    sda_low <= 1'b0;
                        default: state   <= ST_IDLE;
                    endcase
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_start_needs_free_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_IDLE && state == ST_START) |-> !$past(bus_busy));
    p_start_leaves_lines_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_START && state == ST_HOLD) |-> (scl_low && sda_low));
    p_sda_moves_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BIT && $past(state) == ST_BIT && sda_low != $past(sda_low))
        |-> (scl_low && $past(scl_low)));
    p_byte_only_from_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_HOLD && state == ST_BIT) |-> $past(data_go));
    p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!scl_low && !sda_low));
endmodule

// File: rtl/i2c_mtx_regs.sv
// Register file: control, status and data registers, the sticky event
// flag, and qualification of software writes into sequencer commands.
// Assumes one write strobe per cycle at most.
module i2c_mtx_regs
    import i2c_mtx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              bus_busy,
    input  logic              seq_idle,
    input  logic              seq_hold,
    input  logic              evt,
    input  logic              ack_vld,
    input  logic              ack_val,
    output logic              start_req,
    output logic              stop_req,
    output logic              data_go,
    output logic              flag
);
    logic              mst_q, dir_q, qual_q, ack_q;
    logic [DATA_W-1:0] data_q;
    logic              ctrl_wr, data_wr;

    assign ctrl_wr = wr && (addr == A_CTRL);
    assign data_wr = wr && (addr == A_DATA);

    assign start_req = ctrl_wr && wdata[C_BUSY] && !wdata[C_QUAL] &&
                       wdata[C_MST] && wdata[C_DIR] && !bus_busy && seq_idle;
    assign stop_req  = ctrl_wr && !wdata[C_BUSY] && !wdata[C_QUAL] && seq_hold;
    assign data_go   = data_wr && mst_q && dir_q && seq_hold;

    // Stored control fields and the data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_q  <= 1'b0;
            dir_q  <= 1'b0;
            qual_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (ctrl_wr) begin
                mst_q  <= wdata[C_MST];
                dir_q  <= wdata[C_DIR];
                qual_q <= wdata[C_QUAL];
            end
            if (data_wr) data_q <= wdata;
        end
    end

    // Sticky event flag: a hardware event wins over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                          flag <= 1'b0;
        else if (evt)                        flag <= 1'b1;
        else if (ctrl_wr && !wdata[C_FLAG])  flag <= 1'b0;
    end

    // Captured acknowledge level from the ninth clock.
    always_ff @(posedge clk) begin
        if (!rst_n)       ack_q <= 1'b0;
        else if (ack_vld) ack_q <= ack_val;
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[C_BUSY] = bus_busy;
                rdata[C_MST]  = mst_q;
                rdata[C_DIR]  = dir_q;
                rdata[C_QUAL] = qual_q;
                rdata[C_FLAG] = flag;
            end
            A_STAT:  rdata[0] = ack_q;
            A_DATA:  rdata    = data_q;
            default: rdata    = '0;
        endcase
    end

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr && addr == A_CTRL && !wdata[C_FLAG])) |=> flag);
    p_ack_stored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |=> (ack_q == $past(ack_val)) && flag);
endmodule

// File: rtl/i2c_mtx_ctrl.sv
// Top level of the master-transmit controller: register file, bus
// monitor and bus sequencer. Lines are open-drain; the *_drive_low
// outputs pull low when 1. Assumes slaves do not stretch SCL.
module i2c_mtx_ctrl
    import i2c_mtx_pkg::*;
#(
    parameter int CLK_DIV     = 125,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low
);
    logic sda_s, bus_busy, seq_idle, seq_hold, evt, ack_vld, ack_val;
    logic start_req, stop_req, data_go;

    i2c_mtx_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_busmon (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .bus_busy(bus_busy)
    );

    i2c_mtx_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .bus_busy(bus_busy),
        .seq_idle(seq_idle), .seq_hold(seq_hold), .evt(evt),
        .ack_vld(ack_vld), .ack_val(ack_val), .start_req(start_req),
        .stop_req(stop_req), .data_go(data_go), .flag(irq)
    );

    i2c_mtx_seq #(.CLK_DIV(CLK_DIV), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
        .data_go(data_go), .wdata(reg_wdata), .sda_s(sda_s),
        .bus_busy(bus_busy), .seq_idle(seq_idle), .seq_hold(seq_hold),
        .evt(evt), .ack_vld(ack_vld), .ack_val(ack_val),
        .scl_low(scl_drive_low), .sda_low(sda_drive_low)
    );
endmodule

// File: tb/i2c_mtx_ctrl_bench.sv
// Bench: a vector table of bytes with slave responses, walked by one loop
// inside a single transfer, then directed tests for reset and corner cases.
module i2c_mtx_ctrl_bench;
    localparam int DIV = 10;
    localparam int PER = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic irq, scl_dl, sda_dl;
    logic ext_scl = 1'b0, ext_sda = 1'b0, slv_ack = 1'b0;
    wire  scl_line = ~(scl_dl | ext_scl);
    wire  sda_line = ~(sda_dl | ext_sda | slv_ack);

    int checks = 0, errors = 0;
    logic mon_en = 1'b0, ack_en = 1'b1;
    int n_starts = 0, n_stops = 0, rises = 0, hi_bad = 0, hi_cnt = 0;
    logic [7:0] cap = 8'h00, last_byte = 8'h00;
    time t_rise = 0;

    // {no-ack from slave, byte}
    localparam logic [8:0] VEC [0:4] = '{
        {1'b0, 8'hA4}, {1'b0, 8'h3C}, {1'b0, 8'hFF}, {1'b0, 8'h00}, {1'b1, 8'h5A}
    };

    i2c_mtx_ctrl #(.CLK_DIV(DIV)) u_i2c_mtx_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_drive_low(scl_dl), .sda_drive_low(sda_dl)
    );

    always #(PER/2) clk = ~clk;

    // Line monitor and slave model.
    always @(negedge sda_line) if (mon_en && scl_line === 1'b1) begin
        n_starts++; rises = 0;
    end
    always @(posedge sda_line) if (mon_en && scl_line === 1'b1) n_stops++;
    always @(posedge scl_line) if (mon_en) begin
        t_rise = $time; rises++;
        if (rises <= 8) cap = {cap[6:0], sda_line};
    end
    always @(negedge scl_line) if (mon_en && rises > 0) begin
        hi_cnt++;
        if (($time - t_rise) != time'(2*DIV*PER)) hi_bad++;
        if (rises == 8) slv_ack = ack_en;
        if (rises == 9) begin slv_ack = 1'b0; last_byte = cap; rises = 0; end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (irq !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
        chk(irq === 1'b1, req, int'(irq), 1);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * PER);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [7:0] v;
        int s0, p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); mon_en = 1'b1;

        // R1: reset state
        rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
        rd(2'd1, v); chk(v == 8'h00, "R1 stat", v, 0);
        rd(2'd2, v); chk(v == 8'h00, "R1 data", v, 0);
        chk(!irq && !scl_dl && !sda_dl, "R1 lines/irq", {irq, scl_dl, sda_dl}, 0);

        // R7: writing flag bit 1 does not set it (qualifier 1, no command)
        wr(2'd0, 8'h33); repeat (5) @(negedge clk);
        chk(irq == 1'b0, "R7 write-one", irq, 0);

        // R9: data write while bus not owned produces no clock
        wr(2'd2, 8'h55); repeat (4*DIV) @(negedge clk);
        chk(!scl_dl && n_starts == 0, "R9 not owned", scl_dl, 0);

        // R4: start refused with qualifier 1, and without transmit mode
        wr(2'd0, 8'hB2); repeat (6*DIV) @(negedge clk);
        chk(n_starts == 0 && !irq && !sda_dl, "R4 qualifier", n_starts, 0);
        wr(2'd0, 8'hA0); repeat (6*DIV) @(negedge clk);
        chk(n_starts == 0 && !irq && !sda_dl, "R4 mode", n_starts, 0);

        // R2/R4: another master owns the bus
        ext_sda = 1'b1; repeat (6) @(negedge clk);
        rd(2'd0, v); chk(v[7] == 1'b1, "R2 ext start busy", v[7], 1);
        wr(2'd0, 8'hB0); repeat (6*DIV) @(negedge clk);
        chk(!scl_dl && !sda_dl && !irq, "R4 busy bus", {scl_dl, irq}, 0);
        ext_sda = 1'b0; repeat (6) @(negedge clk);
        rd(2'd0, v); chk(v[7] == 1'b0, "R2 ext stop free", v[7], 0);

        // R3: own START
        s0 = n_starts; p0 = n_stops;
        wr(2'd0, 8'hB0);
        wait_irq("R3 flag after start");
        chk(n_starts == s0 + 1, "R3 start seen", n_starts - s0, 1);
        chk(scl_line == 1'b0, "R3 scl low", scl_line, 0);
        rd(2'd0, v); chk(v[7] == 1'b1, "R2 own start busy", v[7], 1);
        repeat (50) @(negedge clk);
        chk(irq == 1'b1, "R7 sticky", irq, 1);

        // Vector loop: R5, R6, R7, R9
        for (int i = 0; i < 5; i++) begin
            ack_en = !VEC[i][8];
            wr(2'd2, VEC[i][7:0]);
            wr(2'd0, 8'hB0);
            chk(irq == 1'b0, "R7 clear", irq, 0);
            if (i == 2) begin
                repeat (3*DIV) @(negedge clk);
                wr(2'd2, 8'h81);   // R9: write while shifting
            end
            wait_irq("R6 flag after byte");
            chk(last_byte == VEC[i][7:0], "R5 byte on bus", last_byte, VEC[i][7:0]);
            rd(2'd1, v); chk(v[0] == VEC[i][8], "R6 ack status", v[0], VEC[i][8]);
        end
        chk(n_starts == s0 + 1 && n_stops == p0, "R5 no stray start/stop",
            n_starts - s0 + n_stops - p0, 1);
        chk(hi_bad == 0 && hi_cnt == 45, "R10 scl high time", hi_bad, 0);

        // R8: STOP
        wr(2'd0, 8'h30);
        repeat (6*DIV) @(negedge clk);
        chk(n_stops == p0 + 1, "R8 stop seen", n_stops - p0, 1);
        chk(!scl_dl && !sda_dl && !irq, "R8 released", {scl_dl, sda_dl, irq}, 0);
        rd(2'd0, v); chk(v[7] == 1'b0, "R8 busy cleared", v[7], 0);

        summary();
    end
endmodule